// File: doc/BRIEF.md
# Flash Block Wear and Bad-Block Tracker

This block holds two pieces of state for every erase block of a NAND die: a counter of erase cycles still allowed and a flag that marks the block as bad. A command sequencer asks it whether a block may be used. It also reports each finished erase, so that the block can charge that erase against the counter of the block that was erased.

Initialisation starts with a single strobe that carries the endurance value. That strobe loads every counter in one cycle. The tracker then reads a list of bad-block indices, one entry per valid beat, and stops at a terminator entry. If an index in the list is out of range, the load is abandoned and a sticky error is raised. An endurance of zero selects unlimited wear, which is stored as an all-ones value that is never decremented. A block whose counter reaches zero is refused from then on, in the same way as a block on the bad list. A validity query is answered in the clock after it is asked.

Top module: `wear_tracker`

## Requirements
- R1: After reset, and before any initialisation has been started, every query is answered with `q_ok` = 0, and `init_busy` = 0 and `init_err` = 0.
- R2: A `cfg_start` strobe with an endurance E that is neither 0 nor all-ones loads E into every counter. A block that is not bad stays valid through E-1 erases and becomes invalid at the E-th erase.
- R3: An endurance of 0 or of all-ones loads the all-ones unlimited value. That value is never decremented, so the block stays valid after any number of erases.
- R4: A list entry whose index is below `NUM_BLOCKS` marks that block bad, and queries for it return invalid.
- R5: While the tracker reads the list, `init_busy` = 1. The list ends at the entry 32'hFFFF_FFFF, which sets the tracker ready and drops `init_busy`. List beats that arrive after the list has ended change no block.
- R6: A list entry that is not 32'hFFFF_FFFF and is at least `NUM_BLOCKS` sets `init_err` = 1 and drops `init_busy`. The error stays set, and every query returns invalid, until the next `cfg_start`.
- R7: An erase decrements a finite counter only while it is above zero. A block at zero stays invalid after further erases, until it is initialised again.
- R8: A query raised on `q_req` in one cycle gives `q_ack` = 1 in the next cycle, and `q_ack` = 0 in every other cycle. A query index at or above `NUM_BLOCKS` is answered invalid.
- R9: An erase strobe has no effect before initialisation, while the list is being read, after an initialisation error, or when its index is at or above `NUM_BLOCKS`.
- R10: A new `cfg_start` in any state clears the error, every bad flag and every counter, and starts a fresh initialisation.
- R11: When a query and an erase name the same block in the same cycle, the answer reflects the state before that erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Starts initialisation and loads every counter |
| cfg_endurance | input | CNT_W | Erase endurance; 0 or all-ones means unlimited |
| bbl_valid | input | 1 | A bad-list entry is present |
| bbl_entry | input | 32 | Bad-list entry: block index or the terminator 32'hFFFF_FFFF |
| init_busy | output | 1 | The bad list is being read |
| init_err | output | 1 | Sticky flag for an out-of-range list entry |
| erase_stb | input | 1 | An erase has completed |
| erase_idx | input | IDX_W | Block that was erased |
| q_req | input | 1 | Validity query request |
| q_idx | input | IDX_W | Block that the query asks about |
| q_ack | output | 1 | Query answer present (one cycle after the request) |
| q_ok | output | 1 | The queried block is usable |

## Verification
The assertions check on every cycle that a zero counter stays at zero, that the unlimited value and the bad flags hold, that an erase removes exactly one cycle, that the fault state holds, that at most one block is marked per list beat, and that each query is answered one clock later. Some behaviour can only be shown by the bench's scenarios, because it depends on the sequence of events. These are the erase count at which each block first becomes invalid (swept over every block), that beats after the terminator and erases during loading are ignored, recovery from the error through a new load, and the pre-erase answer when a query and an erase meet on the same block.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    // Bad-list entries are a fixed 32 bits wide; all-ones closes the list.
    localparam int          ENTRY_W  = 32;
    localparam logic [31:0] LIST_END = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        TRK_UNINIT = 2'd0,
        TRK_LIST   = 2'd1,
        TRK_READY  = 2'd2,
        TRK_FAULT  = 2'd3
    } trk_state_e;

    typedef enum logic [1:0] {
        ENT_MARK  = 2'd0,
        ENT_END   = 2'd1,
        ENT_RANGE = 2'd2
    } entry_kind_e;

    typedef struct packed {
        logic ack;
        logic ok;
    } qry_rsp_t;

    function automatic entry_kind_e classify_entry(input logic [ENTRY_W-1:0] e,
                                                   input int unsigned nblk);
        if (e == LIST_END)
            return ENT_END;
        else if (e >= nblk)
            return ENT_RANGE;
        else
            return ENT_MARK;
    endfunction

endpackage

// File: rtl/wbt_cell.sv
module wbt_cell #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_all,
    input  logic [CNT_W-1:0] load_val,
    input  logic             mark_bad,
    input  logic             wear_dec,
    output logic             ok_o
);
    localparam logic [CNT_W-1:0] UNLIM = '1;

    logic [CNT_W-1:0] cnt;
    logic             bad;
    logic             can_dec;

    assign can_dec = wear_dec && (cnt != '0) && (cnt != UNLIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bad <= 1'b0;
        end else if (load_all) begin
            cnt <= load_val;
            bad <= 1'b0;
        end else begin
            if (mark_bad)
                bad <= 1'b1;
            if (can_dec)
                cnt <= cnt - 1'b1;
        end
    end

    assign ok_o = !bad && (cnt != '0);

    p_zero_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load_all) |=> (cnt == '0));

    p_unlim_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == UNLIM && !load_all) |=> (cnt == UNLIM));

    p_bad_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (bad && !load_all) |=> bad);

    p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
        (wear_dec && cnt != '0 && cnt != UNLIM && !load_all)
            |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/wbt_loader.sv
module wbt_loader
    import wbt_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_start,
    input  logic [CNT_W-1:0]      cfg_endurance,
    input  logic                  bbl_valid,
    input  logic [ENTRY_W-1:0]    bbl_entry,
    output trk_state_e            state_o,
    output logic                  load_all_o,
    output logic [CNT_W-1:0]      load_val_o,
    output logic [NUM_BLOCKS-1:0] mark_o
);
    trk_state_e  state;
    entry_kind_e kind;
    logic        list_take;

    assign kind      = classify_entry(bbl_entry, NUM_BLOCKS);
    assign list_take = (state == TRK_LIST) && bbl_valid && !cfg_start;

    // Zero endurance selects the unlimited all-ones value.
    assign load_all_o = cfg_start;
    assign load_val_o = (cfg_endurance == '0) ? '1 : cfg_endurance;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TRK_UNINIT;
        end else if (cfg_start) begin
            state <= TRK_LIST;
        end else if (list_take) begin
            case (kind)
                ENT_END:   state <= TRK_READY;
                ENT_RANGE: state <= TRK_FAULT;
                default:   state <= TRK_LIST;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_mark
        assign mark_o[i] = list_take && (kind == ENT_MARK)
                           && (bbl_entry == ENTRY_W'(i));
    end

    assign state_o = state;

    p_fault_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (state == TRK_FAULT && !cfg_start) |=> (state == TRK_FAULT));

    p_ready_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state == TRK_READY && !cfg_start) |=> (state == TRK_READY));

    p_start_enters_list_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_start |=> (state == TRK_LIST));

endmodule

// File: rtl/wbt_query.sv
module wbt_query
    import wbt_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ready,
    input  logic [NUM_BLOCKS-1:0] ok_vec,
    input  logic                  q_req,
    input  logic [IDX_W-1:0]      q_idx,
    output logic                  q_ack,
    output logic                  q_ok
);
    localparam int PAD_N = 1 << IDX_W;

    logic [PAD_N-1:0] ok_pad;
    logic             in_range;
    qry_rsp_t         rsp;

    assign ok_pad   = PAD_N'(ok_vec);
    assign in_range = (32'(q_idx) < NUM_BLOCKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.ack <= q_req;
            rsp.ok  <= q_req && ready && in_range && ok_pad[q_idx];
        end
    end

    assign q_ack = rsp.ack;
    assign q_ok  = rsp.ok;

    p_ack_next_r8: assert property (@(posedge clk) disable iff (rst)
        q_req |=> q_ack);

    p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (rst)
        !q_req |=> !q_ack);

    p_oor_invalid_r8: assert property (@(posedge clk) disable iff (rst)
        (q_req && !in_range) |=> !q_ok);

    p_not_ready_invalid_r6: assert property (@(posedge clk) disable iff (rst)
        (q_req && !ready) |=> !q_ok);

endmodule

// File: rtl/wear_tracker.sv
module wear_tracker
    import wbt_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int CNT_W      = 8,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_start,
    input  logic [CNT_W-1:0]   cfg_endurance,
    input  logic               bbl_valid,
    input  logic [31:0]        bbl_entry,
    output logic               init_busy,
    output logic               init_err,
    input  logic               erase_stb,
    input  logic [IDX_W-1:0]   erase_idx,
    input  logic               q_req,
    input  logic [IDX_W-1:0]   q_idx,
    output logic               q_ack,
    output logic               q_ok
);
    trk_state_e            state;
    logic                  load_all;
    logic [CNT_W-1:0]      load_val;
    logic [NUM_BLOCKS-1:0] mark_vec;
    logic [NUM_BLOCKS-1:0] wear_dec;
    logic [NUM_BLOCKS-1:0] ok_vec;
    logic                  ready;

    assign ready = (state == TRK_READY);

    wbt_loader #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .CNT_W      (CNT_W)
    ) u_loader (
        .clk           (clk),
        .rst           (rst),
        .cfg_start     (cfg_start),
        .cfg_endurance (cfg_endurance),
        .bbl_valid     (bbl_valid),
        .bbl_entry     (bbl_entry),
        .state_o       (state),
        .load_all_o    (load_all),
        .load_val_o    (load_val),
        .mark_o        (mark_vec)
    );

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        assign wear_dec[i] = erase_stb && ready && (erase_idx == IDX_W'(i));

        wbt_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .load_all (load_all),
            .load_val (load_val),
            .mark_bad (mark_vec[i]),
            .wear_dec (wear_dec[i]),
            .ok_o     (ok_vec[i])
        );
    end

    wbt_query #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W)
    ) u_query (
        .clk    (clk),
        .rst    (rst),
        .ready  (ready),
        .ok_vec (ok_vec),
        .q_req  (q_req),
        .q_idx  (q_idx),
        .q_ack  (q_ack),
        .q_ok   (q_ok)
    );

    assign init_busy = (state == TRK_LIST);
    assign init_err  = (state == TRK_FAULT);

    p_mark_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mark_vec));

    p_ok_needs_ack_r8: assert property (@(posedge clk) disable iff (rst)
        q_ok |-> q_ack);

    p_busy_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(init_busy && init_err));

endmodule

// File: tb/wear_tracker_bench.sv
`timescale 1ns/1ps
module wear_tracker_bench;
    localparam int N     = 12;
    localparam int CW    = 8;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_start = 1'b0;
    logic [CW-1:0] cfg_endurance = '0;
    logic          bbl_valid = 1'b0;
    logic [31:0]   bbl_entry = '0;
    logic          init_busy, init_err;
    logic          erase_stb = 1'b0;
    logic [IW-1:0] erase_idx = '0;
    logic          q_req = 1'b0;
    logic [IW-1:0] q_idx = '0;
    logic          q_ack, q_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model built from the requirements.
    int m_cnt [N];
    bit m_bad [N];
    bit m_unl;
    int m_state; // 0 none, 1 list, 2 ready, 3 fault

    always #10 clk = ~clk;

    wear_tracker #(.NUM_BLOCKS(N), .CNT_W(CW)) u_wear_tracker (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_endurance(cfg_endurance),
        .bbl_valid(bbl_valid), .bbl_entry(bbl_entry), .init_busy(init_busy),
        .init_err(init_err), .erase_stb(erase_stb), .erase_idx(erase_idx),
        .q_req(q_req), .q_idx(q_idx), .q_ack(q_ack), .q_ok(q_ok)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic bit exp_ok(input int idx);
        if (m_state != 2 || idx >= N) return 1'b0;
        return !m_bad[idx] && (m_unl || m_cnt[idx] > 0);
    endfunction

    task automatic start_init(input int e);
        @(negedge clk);
        cfg_start = 1'b1;
        cfg_endurance = CW'(e);
        @(negedge clk);
        cfg_start = 1'b0;
        m_unl = (e == 0) || (e == (1 << CW) - 1);
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = e;
            m_bad[i] = 1'b0;
        end
        m_state = 1;
    endtask

    task automatic push(input logic [31:0] e);
        bbl_valid = 1'b1;
        bbl_entry = e;
        @(negedge clk);
        bbl_valid = 1'b0;
        if (m_state == 1) begin
            if (e == 32'hFFFF_FFFF) m_state = 2;
            else if (e >= N)        m_state = 3;
            else                    m_bad[e] = 1'b1;
        end
    endtask

    task automatic erase(input int idx);
        erase_stb = 1'b1;
        erase_idx = IW'(idx);
        @(negedge clk);
        erase_stb = 1'b0;
        if (m_state == 2 && idx < N && !m_unl && m_cnt[idx] > 0)
            m_cnt[idx]--;
    endtask

    task automatic query(input int idx, input string tag);
        bit e;
        e = exp_ok(idx);
        q_req = 1'b1;
        q_idx = IW'(idx);
        @(negedge clk);
        q_req = 1'b0;
        check({tag, " ack"}, q_ack, 1'b1);
        check({tag, " ok"}, q_ok, e);
    endtask

    task automatic query_all(input string tag);
        for (int b = 0; b < N; b++) query(b, tag);
    endtask

    initial begin
        m_state = 0;
        m_unl = 1'b0;
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_bad[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", init_busy, 1'b0);
        check("R1 err", init_err, 1'b0);
        check("R1 idle ack", q_ack, 1'b0);
        erase(0); // R9: erase before init
        query(0, "R1 uninit query");

        // R2 R4 R5: finite endurance with a bad list
        start_init(3);
        check("R5 busy during list", init_busy, 1'b1);
        push(32'd2);
        push(32'd7);
        check("R5 busy before end", init_busy, 1'b1);
        erase(0); // R9: erase while loading is ignored
        push(32'hFFFF_FFFF);
        check("R5 busy after end", init_busy, 1'b0);
        check("R5 no err", init_err, 1'b0);
        push(32'd5); // R5: beat after terminator ignored
        query_all("R4 bad marks");
        query(12, "R8 oor query");
        query(15, "R8 oor query");

        // R2 R7: sweep erases over every block
        for (int b = 0; b < N; b++) begin
            for (int k = 0; k < 4; k++) begin
                erase(b);
                query(b, "R2 R7 wear sweep");
            end
        end
        erase(14); // R9: out-of-range erase
        query_all("R9 oor erase");

        // R11: same-cycle query and erase
        start_init(2);
        push(32'hFFFF_FFFF);
        erase(0);
        q_req = 1'b1; q_idx = '0;
        erase_stb = 1'b1; erase_idx = '0;
        @(negedge clk);
        q_req = 1'b0; erase_stb = 1'b0;
        check("R11 pre-erase answer", q_ok, 1'b1);
        m_cnt[0] = 0;
        query(0, "R11 after erase");

        // R3: unlimited by zero and by all-ones
        start_init(0);
        push(32'hFFFF_FFFF);
        for (int k = 0; k < 300; k++) erase(4);
        query(4, "R3 zero endurance");
        start_init(255);
        push(32'hFFFF_FFFF);
        for (int k = 0; k < 300; k++) erase(5);
        query(5, "R3 all-ones endurance");

        // R6: out-of-range list entry
        start_init(2);
        push(32'd3);
        push(32'd12);
        check("R6 err set", init_err, 1'b1);
        check("R6 busy dropped", init_busy, 1'b0);
        push(32'hFFFF_FFFF);
        erase(0);
        check("R6 err sticky", init_err, 1'b1);
        query(0, "R6 fault query");

        // R10: re-initialise clears everything
        start_init(2);
        check("R10 err cleared", init_err, 1'b0);
        push(32'hFFFF_FFFF);
        query_all("R10 reinit");
        erase(3);
        erase(3);
        query(3, "R7 block at zero");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule